// File: doc/BRIEF.md
# RC Potentiometer Charge Timer

This block measures the positions of several analog joystick axes. Each axis is a pad with a capacitor to ground and a potentiometer pull-up to the supply. When the block is started, it pulls every axis pad low for a fixed discharge period. It then releases all pads together and runs one shared counter. Each axis keeps the counter value from the first clock on which its synchronized pad input reads high. A larger potentiometer resistance charges the capacitor more slowly and so gives a larger count.

The pads themselves sit outside the block. Each axis has an output-enable: while it is asserted the pad is driven low, and when it is cleared the pad floats. A count limit acts as a timeout, so a disconnected axis cannot hang a measurement. The button inputs are synchronized and latched when the measurement ends. The results then stay unchanged until software issues the next start.

Top module: `rcpot_timer`

## Requirements
- R1: While reset is asserted and until the first start, all of these are 0: `busy_o`, `done_o`, every `axis_oe_o` bit, every count, every timeout flag and every button bit.
- R2: A start sampled high while idle raises `busy_o` on that edge. From that edge on, all `axis_oe_o` bits are 1 together for exactly DISCH_CYCLES clock cycles, and then all fall together.
- R3: The rising edge on which `axis_oe_o` falls is the release edge. An axis whose pad is first sampled high on the D-th rising edge after the release edge reports a count of D+1, with its timeout flag at 0.
- R4: All axes are timed at the same time against the one shared counter. Each axis stops on its own high reading, and its count lives in bits [a*CNT_W +: CNT_W] of `axis_count_o`.
- R5: An axis that is still not captured when the counter reaches MAX_COUNT reports a count of MAX_COUNT and sets its `axis_tmo_o` bit. This happens on the rising edge D = MAX_COUNT+1 after release.
- R6: At the boundary, a pad first sampled high at D = MAX_COUNT-1 reports exactly MAX_COUNT with its timeout flag at 0. A pad first sampled high at D = MAX_COUNT or later times out.
- R7: `done_o` is high for exactly one cycle. It rises one rising edge after the last axis has captured or timed out, and `busy_o` falls on that same edge.
- R8: A count is taken on the first high sample only. A pad that goes high and then falls back low before the end of the measurement keeps its count, and its timeout flag stays 0.
- R9: A start pulse that arrives during the discharge or counting phase is ignored. The pads are not driven low again, the counts are not cleared, and `done_o` comes at the same cycle as without that pulse.
- R10: `btn_o[i]` reports `btn_i[i]`. The value passes through two synchronizer stages and is latched on the edge where `done_o` rises.
- R11: After `done_o`, the counts, the timeout flags and the button bits hold unchanged until the next accepted start, whatever the pads and buttons do in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begins a measurement when the block is idle |
| axis_pin_i | input | NUM_AXES | Pad levels of the axes (asynchronous) |
| btn_i | input | NUM_BTN | Button levels (asynchronous) |
| axis_oe_o | output | NUM_AXES | 1 drives the pad low, 0 releases it |
| busy_o | output | 1 | A measurement is running |
| done_o | output | 1 | One-cycle completion pulse |
| axis_count_o | output | NUM_AXES*CNT_W | Packed per-axis charge counts |
| axis_tmo_o | output | NUM_AXES | Per-axis timeout flags |
| btn_o | output | NUM_BTN | Latched button bits |

## Verification
The hardest cases to reach from the ports are the ones right at the count limit. These are a pad that settles on the last countable cycle, and a pad that misses the limit by one cycle. Both depend on the two synchronizer stages and on the capture edge lining up exactly.

The bench models each pad as a capacitor. Its level goes high a programmed number of clocks after the block releases it. The bench sets the delays to MAX_COUNT-1 and to MAX_COUNT on different axes within the same run, so both cases occur together. Two further stimuli are a pad that rises and then drops again, and start pulses injected in the middle of a run. For these, the bench checks the completion cycle against a cycle count it computes itself.

// File: rtl/rcpot_pkg.sv
package rcpot_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_DRAIN = 2'd1,
      PH_TIME  = 2'd2
   } rc_phase_e;
endpackage

// File: rtl/rcpot_sync.sv
module rcpot_sync #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] stage1, stage2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage1 <= '0;
         stage2 <= '0;
      end else begin
         stage1 <= d_i;
         stage2 <= stage1;
      end
   end

   assign q_o = stage2;
endmodule

// File: rtl/rcpot_seq.sv
module rcpot_seq
   import rcpot_pkg::*;
#(
   parameter int CNT_W        = 16,
   parameter int DISCH_CYCLES = 256,
   parameter int MAX_COUNT    = 60000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             all_settled_i,
   output rc_phase_e        phase_o,
   output logic [CNT_W-1:0] tick_o,
   output logic             clear_o,
   output logic             finish_o,
   output logic             done_o
);
   localparam int DW = (DISCH_CYCLES > 2) ? $clog2(DISCH_CYCLES) : 2;
   localparam logic [DW-1:0]    DRAIN_LAST = DW'(DISCH_CYCLES - 1);
   localparam logic [CNT_W-1:0] TICK_CAP   = CNT_W'(MAX_COUNT);

   rc_phase_e        phase;
   logic [DW-1:0]    drain_cnt;
   logic [CNT_W-1:0] tick;
   logic             done_q;

   assign clear_o  = (phase == PH_IDLE) && start_i;
   assign finish_o = (phase == PH_TIME) && all_settled_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         drain_cnt <= '0;
         tick      <= '0;
         done_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (phase)
            PH_IDLE: begin
               if (start_i) begin
                  phase     <= PH_DRAIN;
                  drain_cnt <= '0;
               end
            end
            PH_DRAIN: begin
               if (drain_cnt == DRAIN_LAST) begin
                  phase <= PH_TIME;
                  tick  <= '0;
               end else begin
                  drain_cnt <= drain_cnt + 1'b1;
               end
            end
            PH_TIME: begin
               if (all_settled_i) begin
                  phase  <= PH_IDLE;
                  done_q <= 1'b1;
               end else if (tick != TICK_CAP) begin
                  tick <= tick + 1'b1;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign phase_o = phase;
   assign tick_o  = tick;
   assign done_o  = done_q;
endmodule

// File: rtl/rcpot_axis.sv
module rcpot_axis #(
   parameter int CNT_W     = 16,
   parameter int MAX_COUNT = 60000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             timing_i,
   input  logic             pin_s_i,
   input  logic [CNT_W-1:0] tick_i,
   output logic [CNT_W-1:0] count_o,
   output logic             tmo_o,
   output logic             settled_o
);
   localparam logic [CNT_W-1:0] TICK_CAP = CNT_W'(MAX_COUNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_o   <= '0;
         tmo_o     <= 1'b0;
         settled_o <= 1'b0;
      end else if (clear_i) begin
         count_o   <= '0;
         tmo_o     <= 1'b0;
         settled_o <= 1'b0;
      end else if (timing_i && !settled_o) begin
         if (pin_s_i) begin
            count_o   <= tick_i;
            settled_o <= 1'b1;
         end else if (tick_i == TICK_CAP) begin
            count_o   <= TICK_CAP;
            tmo_o     <= 1'b1;
            settled_o <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/rcpot_timer.sv
module rcpot_timer
   import rcpot_pkg::*;
#(
   parameter int NUM_AXES     = 4,
   parameter int NUM_BTN      = 4,
   parameter int CNT_W        = 16,
   parameter int DISCH_CYCLES = 256,
   parameter int MAX_COUNT    = 60000
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start_i,
   input  logic [NUM_AXES-1:0]       axis_pin_i,
   input  logic [NUM_BTN-1:0]        btn_i,
   output logic [NUM_AXES-1:0]       axis_oe_o,
   output logic                      busy_o,
   output logic                      done_o,
   output logic [NUM_AXES*CNT_W-1:0] axis_count_o,
   output logic [NUM_AXES-1:0]       axis_tmo_o,
   output logic [NUM_BTN-1:0]        btn_o
);
   localparam longint CNT_CEIL = (64'd1 << CNT_W) - 1;

   if (NUM_AXES < 1 || NUM_BTN < 1) begin : g_bad_count
      $error("rcpot_timer: NUM_AXES and NUM_BTN must be at least 1");
   end
   if (CNT_W < 2 || CNT_W > 31) begin : g_bad_width
      $error("rcpot_timer: CNT_W out of range");
   end
   if (DISCH_CYCLES < 3) begin : g_bad_drain
      $error("rcpot_timer: DISCH_CYCLES must cover the synchronizer flush");
   end
   if (MAX_COUNT < 2 || longint'(MAX_COUNT) > CNT_CEIL) begin : g_bad_max
      $error("rcpot_timer: MAX_COUNT does not fit CNT_W");
   end

   rc_phase_e        phase;
   logic [CNT_W-1:0] tick;
   logic             clear, finish;
   logic [NUM_AXES-1:0] pin_s, settled;
   logic [NUM_BTN-1:0]  btn_s;

   rcpot_sync #(.W(NUM_AXES)) u_pin_sync (
      .clk(clk), .rst_n(rst_n), .d_i(axis_pin_i), .q_o(pin_s)
   );

   rcpot_sync #(.W(NUM_BTN)) u_btn_sync (
      .clk(clk), .rst_n(rst_n), .d_i(btn_i), .q_o(btn_s)
   );

   rcpot_seq #(
      .CNT_W(CNT_W), .DISCH_CYCLES(DISCH_CYCLES), .MAX_COUNT(MAX_COUNT)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .all_settled_i(&settled),
      .phase_o(phase), .tick_o(tick), .clear_o(clear),
      .finish_o(finish), .done_o(done_o)
   );

   for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
      rcpot_axis #(.CNT_W(CNT_W), .MAX_COUNT(MAX_COUNT)) u_axis (
         .clk(clk), .rst_n(rst_n),
         .clear_i(clear),
         .timing_i(phase == PH_TIME),
         .pin_s_i(pin_s[a]),
         .tick_i(tick),
         .count_o(axis_count_o[a*CNT_W +: CNT_W]),
         .tmo_o(axis_tmo_o[a]),
         .settled_o(settled[a])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      btn_o <= '0;
      else if (finish) btn_o <= btn_s;
   end

   assign axis_oe_o = {NUM_AXES{phase == PH_DRAIN}};
   assign busy_o    = (phase != PH_IDLE);
endmodule

// File: rtl/rcpot_chk.sv
module rcpot_chk #(
   parameter int NUM_AXES  = 4,
   parameter int NUM_BTN   = 4,
   parameter int CNT_W     = 16,
   parameter int MAX_COUNT = 60000
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [NUM_AXES-1:0]       axis_oe_o,
   input logic                      busy_o,
   input logic                      done_o,
   input logic [NUM_AXES*CNT_W-1:0] axis_count_o,
   input logic [NUM_AXES-1:0]       axis_tmo_o,
   input logic [NUM_BTN-1:0]        btn_o
);
   a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !busy_o && !done_o);

   a_r2_oe_all_or_none: assert property (@(posedge clk) disable iff (!rst_n)
      (axis_oe_o == '0) || (axis_oe_o == '1));

   a_r2_oe_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (axis_oe_o != '0) |-> busy_o);

   a_r2_busy_starts_drain: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> (axis_oe_o == '1));

   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   a_r9_no_redrain: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && $past(busy_o) && ($past(axis_oe_o) == '0) |-> (axis_oe_o == '0));

   a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o && !$past(busy_o) |->
         $stable(axis_count_o) && $stable(axis_tmo_o) && $stable(btn_o));

   for (genvar a = 0; a < NUM_AXES; a++) begin : g_ax
      a_r5_tmo_saturates: assert property (@(posedge clk) disable iff (!rst_n)
         axis_tmo_o[a] |-> (axis_count_o[a*CNT_W +: CNT_W] == CNT_W'(MAX_COUNT)));
      a_r5_never_above: assert property (@(posedge clk) disable iff (!rst_n)
         axis_count_o[a*CNT_W +: CNT_W] <= CNT_W'(MAX_COUNT));
   end
endmodule

bind rcpot_timer rcpot_chk #(
   .NUM_AXES(NUM_AXES), .NUM_BTN(NUM_BTN), .CNT_W(CNT_W), .MAX_COUNT(MAX_COUNT)
) u_rcpot_chk (
   .clk(clk), .rst_n(rst_n), .axis_oe_o(axis_oe_o), .busy_o(busy_o),
   .done_o(done_o), .axis_count_o(axis_count_o), .axis_tmo_o(axis_tmo_o),
   .btn_o(btn_o)
);

// File: tb/tb_rcpot_timer.sv
module tb_rcpot_timer;
   localparam int NA    = 4;
   localparam int NB    = 4;
   localparam int CW    = 10;
   localparam int DRAIN = 6;
   localparam int MAXC  = 200;
   localparam int NEVER = 1000000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [NA-1:0] pin = '0;
   logic [NB-1:0] btn = '0;
   logic [NA-1:0] oe;
   logic busy, done;
   logic [NA*CW-1:0] counts;
   logic [NA-1:0] tmo;
   logic [NB-1:0] btn_q;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int dly [NA];
   bit glitch [NA];
   int rel [NA];

   always #2ns clk = ~clk;

   rcpot_timer #(
      .NUM_AXES(NA), .NUM_BTN(NB), .CNT_W(CW),
      .DISCH_CYCLES(DRAIN), .MAX_COUNT(MAXC)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .axis_pin_i(pin),
      .btn_i(btn), .axis_oe_o(oe), .busy_o(busy), .done_o(done),
      .axis_count_o(counts), .axis_tmo_o(tmo), .btn_o(btn_q)
   );

   // RC pad model: the level rises dly clocks after the pad is released
   always @(negedge clk) begin
      for (int a = 0; a < NA; a++) begin
         if (oe[a]) rel[a] = 0;
         else if (rel[a] < NEVER) rel[a] = rel[a] + 1;
         pin[a] = !oe[a] && (rel[a] >= dly[a]) &&
                  (!glitch[a] || rel[a] < dly[a] + 3);
      end
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         bad = bad + 1;
         total = total + 1;
         $display("FAIL watchdog: act=%0d exp<=150000", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input string req, input longint act, input longint exp);
      total = total + 1;
      if (act != exp) begin
         bad = bad + 1;
         $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
      end
   endtask

   function automatic int cnt_of(input int a);
      return int'(counts[a*CW +: CW]);
   endfunction

   // Runs one measurement; poke > 0 injects an extra start at that cycle (R9)
   task automatic run_meas(input string tag, input int poke);
      int n = 0;
      int oe_n = 0;
      int split = 0;
      int deff = 0;
      bit got = 0;
      for (int a = 0; a < NA; a++) begin
         int d = (dly[a] >= MAXC) ? MAXC - 1 : dly[a];
         if (d > deff) deff = d;
      end
      @(negedge clk);
      start = 1'b1;
      while (!got && n < 3000) begin
         @(negedge clk);
         n++;
         start = (poke > 0 && n == poke);
         if (oe != '0) oe_n++;
         if (oe != '0 && oe != '1) split++;
         got = done;
      end
      start = 1'b0;
      $display("run %s: %0d cycles", tag, n);
      chk({"R7 done cycle ", tag}, n, DRAIN + deff + 4);
      chk({"R2 drain length ", tag}, oe_n, DRAIN);
      chk({"R2 pads together ", tag}, split, 0);
      chk({"R7 busy low at done ", tag}, busy, 0);
      for (int a = 0; a < NA; a++) begin
         if (dly[a] >= MAXC) begin
            chk({"R5 timeout count ", tag}, cnt_of(a), MAXC);
            chk({"R5 timeout flag ", tag}, tmo[a], 1);
         end else begin
            chk({"R3 R4 count ", tag}, cnt_of(a), dly[a] + 1);
            chk({"R3 no timeout ", tag}, tmo[a], 0);
         end
      end
      chk({"R10 buttons ", tag}, btn_q, btn);
      @(negedge clk);
      chk({"R7 done one cycle ", tag}, done, 0);
   endtask

   task automatic t_reset();
      chk("R1 busy", busy, 0);
      chk("R1 done", done, 0);
      chk("R1 oe", oe, 0);
      chk("R1 counts", counts, 0);
      chk("R1 tmo", tmo, 0);
      chk("R1 btn", btn_q, 0);
   endtask

   task automatic t_basic();
      dly = '{5, 20, 40, 77};
      glitch = '{0, 0, 0, 0};
      btn = 4'b1010;
      run_meas("basic", 0);
   endtask

   task automatic t_equal();
      dly = '{10, 10, 10, 10};
      btn = 4'b0101;
      run_meas("equal", 0);
   endtask

   task automatic t_timeout();
      dly = '{3, 50, NEVER, 9};
      btn = 4'b0001;
      run_meas("timeout", 0);
   endtask

   task automatic t_boundary();
      // R6: MAXC-1 fits exactly, MAXC misses by one
      dly = '{MAXC - 1, MAXC, 1, 2};
      btn = 4'b1000;
      run_meas("R6 boundary", 0);
      chk("R6 last countable", cnt_of(0), MAXC);
      chk("R6 one too late", tmo[1], 1);
   endtask

   task automatic t_ignore_start();
      dly = '{30, 12, 25, 8};
      btn = 4'b1111;
      run_meas("R9 poke in count", DRAIN + 5);
      run_meas("R9 poke in drain", 2);
   endtask

   task automatic t_glitch();
      dly = '{15, 6, 60, 22};
      glitch = '{1, 0, 1, 0};
      btn = 4'b0110;
      run_meas("R8 glitch", 0);
      glitch = '{0, 0, 0, 0};
   endtask

   task automatic t_hold();
      int c0 = cnt_of(0);
      int c3 = cnt_of(3);
      logic [NA-1:0] t0 = tmo;
      logic [NB-1:0] b0 = btn_q;
      btn = ~btn;
      dly = '{1, 1, 1, 1};
      repeat (25) @(negedge clk);
      chk("R11 count0 held", cnt_of(0), c0);
      chk("R11 count3 held", cnt_of(3), c3);
      chk("R11 tmo held", tmo, t0);
      chk("R11 btn held", btn_q, b0);
      chk("R11 stays idle", busy, 0);
   endtask

   initial begin
      dly = '{NEVER, NEVER, NEVER, NEVER};
      glitch = '{0, 0, 0, 0};
      for (int a = 0; a < NA; a++) rel[a] = 0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      t_basic();
      t_equal();
      t_timeout();
      t_hold();
      t_boundary();
      t_ignore_start();
      t_glitch();
      t_hold();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule